// File: doc/BRIEF.md
# Oscillator Stabilization Wait Timer

This block keeps the internal clock gated off after the main oscillator restarts, until a chosen number of oscillator cycles has gone by. Software picks the wait length through a one-byte select register. The wait runs whenever the standby stop state ends. That happens in two ways: a wake request ends it, or a reset ends it. A reset release always uses a fixed wait of 2^19 cycles, whatever the register holds.

Only cycles in which the oscillator-running flag is high count toward the wait, so the oscillator's own start-up delay is never part of the count. The parameter `SHIFT` divides every count by 2^SHIFT. This shortens simulation and keeps the ratios between select codes exact.

Top module: `osc_settle_timer`

## Requirements
- R1: While reset is applied and on the first cycle after it, `reg_rdata` reads 8'h04, and `clk_en`, `stop_active` and `settle_done` are 0.
- R2: A register write with `reg_wr_en`=1 and `reg_wr_byte`=1 stores `reg_wdata[2:0]` as the select code. `reg_rdata` then returns {5'b0, code}, so bits 7:3 always read 0.
- R3: A write with `reg_wr_byte`=0, meaning an access of other than 8 bits, leaves `reg_rdata` unchanged.
- R4: After a wake-driven release, `clk_en` rises after N = 2^(E-SHIFT) clock edges that have `osc_run` high, counted from the edge that accepted the wake. E is 14 for code 000 and 15+code for codes 001 to 111 (2^16 up to 2^22). There is no 2^15 setting.
- R5: After reset is removed, the block waits, and `clk_en` rises after 2^(19-SHIFT) edges that have `osc_run` high. This holds even if the register is written during that wait.
- R6: Edges on which `osc_run` is low do not advance the wait. This applies both before the oscillator starts and during a dropout in mid-wait.
- R7: A `stop_req` while running drives `clk_en` to 0 and `stop_active` to 1 on the next edge. A `wake_req` while stopped clears `stop_active` on the next edge and starts the wait, with `clk_en` still 0.
- R8: A register write during a wait does not change the length of that wait. The new code sets the length of the next wake-driven wait.
- R9: `settle_done` is high for exactly one cycle, the same cycle in which `clk_en` first reads 1. The block then stays running with `clk_en`=1 and no further pulse until the next stop.
- R10: A `wake_req` while running has no effect on the outputs. A `stop_req` during a wait is ignored and does not change that wait's length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Main oscillator clock |
| rst | input | 1 | Synchronous active-high reset; its release starts a fixed-length wait |
| stop_req | input | 1 | Request to enter the stop state (acted on only while running) |
| wake_req | input | 1 | Interrupt-driven request to leave the stop state |
| osc_run | input | 1 | High while the oscillator is actually oscillating |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wr_byte | input | 1 | High when the access is 8 bits wide |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register readback {5'b0, select code} |
| clk_en | output | 1 | Internal clock enable; low while stopped or waiting |
| stop_active | output | 1 | High while in the stop state |
| settle_done | output | 1 | One-cycle pulse when the wait completes |

## Verification
Some behaviours are checked on every cycle by the assertions:
- the done pulse lasts one cycle and coincides with the rise of the clock enable;
- the clock enable stays low while stopped;
- the counter never passes the latched terminal value and holds on cycles without oscillation;
- the terminal value stays frozen for the whole of a wait.

Other behaviours can only be shown by the bench's scenarios:
- the exact length of each wait for every select code and for a reset release, which confirms the skipped 2^15 step and the fixed 2^19 reset count;
- the extra cycles added by oscillator dropouts;
- the deferral of a write made during a wait until the next release.

// File: rtl/osw_pkg.sv
package osw_pkg;
  localparam int MAX_EXP = 22;
  localparam int RST_EXP = 19;
  localparam logic [2:0] RST_CODE = 3'd4;

  typedef enum logic [1:0] {ST_WAIT, ST_RUN, ST_STOP} osw_state_t;

  // select code to power-of-two exponent; the 2^15 step does not exist
  function automatic int sel_exponent(logic [2:0] code);
    return (code == 3'd0) ? 14 : 15 + int'(code);
  endfunction
endpackage

// File: rtl/osw_regif.sv
module osw_regif (
  input  logic       clk,
  input  logic       rst,
  input  logic       wr_en,
  input  logic       wr_byte,
  input  logic [7:0] wdata,
  output logic [2:0] sel,
  output logic [7:0] rdata
);
  logic unused_hi;
  assign unused_hi = ^wdata[7:3];

  always_ff @(posedge clk) begin
    if (rst)                   sel <= osw_pkg::RST_CODE;
    else if (wr_en && wr_byte) sel <= wdata[2:0];
  end

  assign rdata = {5'b0, sel};

  assert_reg_hold_R3: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !wr_byte) |=> $stable(sel));
endmodule

// File: rtl/osw_counter.sv
module osw_counter #(
  parameter int CW = 12
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          en,
  input  logic [CW-1:0] term_m1,
  output logic          hit
);
  logic [CW-1:0] cnt;

  assign hit = en && (cnt == term_m1);

  always_ff @(posedge clk) begin
    if (rst || clr || hit) cnt <= '0;
    else if (en)           cnt <= cnt + 1'b1;
  end

  assert_cnt_bound_R4: assert property (@(posedge clk) disable iff (rst)
    cnt <= term_m1);
  assert_cnt_stall_R6: assert property (@(posedge clk) disable iff (rst)
    (!en && !clr) |=> $stable(cnt));
endmodule

// File: rtl/osw_ctrl.sv
module osw_ctrl #(
  parameter int SHIFT = 10,
  parameter int CW    = 12
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          stop_req,
  input  logic          wake_req,
  input  logic          osc_run,
  input  logic [2:0]    sel,
  input  logic          hit,
  output logic          cnt_en,
  output logic          cnt_clr,
  output logic [CW-1:0] term_m1,
  output logic          clk_en,
  output logic          stop_active,
  output logic          settle_done
);
  import osw_pkg::*;

  function automatic logic [CW-1:0] term_of(int e);
    return CW'((longint'(1) << (e - SHIFT)) - longint'(1));
  endfunction

  osw_state_t state;

  assign cnt_en  = (state == ST_WAIT) && osc_run;
  assign cnt_clr = (state != ST_WAIT);

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= ST_WAIT;            // reset ends stop: fixed wait follows
      term_m1     <= term_of(RST_EXP);
      clk_en      <= 1'b0;
      stop_active <= 1'b0;
      settle_done <= 1'b0;
    end else begin
      settle_done <= 1'b0;
      case (state)
        ST_WAIT: if (hit) begin
          state       <= ST_RUN;
          clk_en      <= 1'b1;
          settle_done <= 1'b1;
        end
        ST_RUN: if (stop_req) begin
          state       <= ST_STOP;
          clk_en      <= 1'b0;
          stop_active <= 1'b1;
        end
        ST_STOP: if (wake_req) begin
          state       <= ST_WAIT;
          stop_active <= 1'b0;
          term_m1     <= term_of(sel_exponent(sel));
        end
        default: state <= ST_STOP;
      endcase
    end
  end

  assert_done_once_R9: assert property (@(posedge clk) disable iff (rst)
    settle_done |=> !settle_done);
  assert_done_edge_R9: assert property (@(posedge clk) disable iff (rst)
    $rose(clk_en) |-> settle_done);
  assert_stop_gate_R7: assert property (@(posedge clk) disable iff (rst)
    stop_active |-> !clk_en);
  assert_term_hold_R8: assert property (@(posedge clk) disable iff (rst)
    (state == ST_WAIT && $past(state) == ST_WAIT) |-> $stable(term_m1));
endmodule

// File: rtl/osc_settle_timer.sv
module osc_settle_timer #(
  parameter int SHIFT = 10
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       stop_req,
  input  logic       wake_req,
  input  logic       osc_run,
  input  logic       reg_wr_en,
  input  logic       reg_wr_byte,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  output logic       clk_en,
  output logic       stop_active,
  output logic       settle_done
);
  localparam int CW = osw_pkg::MAX_EXP - SHIFT;

  logic [2:0]    sel;
  logic          hit, cnt_en, cnt_clr;
  logic [CW-1:0] term_m1;

  osw_regif u_reg (
    .clk(clk), .rst(rst), .wr_en(reg_wr_en), .wr_byte(reg_wr_byte),
    .wdata(reg_wdata), .sel(sel), .rdata(reg_rdata)
  );

  osw_counter #(.CW(CW)) u_cnt (
    .clk(clk), .rst(rst), .clr(cnt_clr), .en(cnt_en),
    .term_m1(term_m1), .hit(hit)
  );

  osw_ctrl #(.SHIFT(SHIFT), .CW(CW)) u_ctrl (
    .clk(clk), .rst(rst), .stop_req(stop_req), .wake_req(wake_req),
    .osc_run(osc_run), .sel(sel), .hit(hit), .cnt_en(cnt_en),
    .cnt_clr(cnt_clr), .term_m1(term_m1), .clk_en(clk_en),
    .stop_active(stop_active), .settle_done(settle_done)
  );
endmodule

// File: tb/sim_osc_settle_timer.sv
module sim_osc_settle_timer;
  localparam int S = 10;

  logic clk = 1'b0;
  logic rst, stop_req, wake_req, osc_run, reg_wr_en, reg_wr_byte;
  logic [7:0] reg_wdata, reg_rdata;
  logic clk_en, stop_active, settle_done;
  int checks = 0, fails = 0;

  always #2 clk = ~clk;

  osc_settle_timer #(.SHIFT(S)) u0 (
    .clk(clk), .rst(rst), .stop_req(stop_req), .wake_req(wake_req),
    .osc_run(osc_run), .reg_wr_en(reg_wr_en), .reg_wr_byte(reg_wr_byte),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .clk_en(clk_en),
    .stop_active(stop_active), .settle_done(settle_done)
  );

  // write data, expected readback
  localparam logic [7:0] VWR [8] = '{8'hF8, 8'h01, 8'hAA, 8'h03, 8'h0C, 8'hFD, 8'h06, 8'h07};
  localparam logic [7:0] VRD [8] = '{8'h00, 8'h01, 8'h02, 8'h03, 8'h04, 8'h05, 8'h06, 8'h07};

  function automatic int wait_len(logic [2:0] code);
    int e = (code == 3'd0) ? 14 : 15 + int'(code);
    return 1 << (e - S);
  endfunction

  task automatic chk(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  endtask

  task automatic wr(bit byte_acc, logic [7:0] v);
    @(negedge clk);
    reg_wr_en = 1'b1; reg_wr_byte = byte_acc; reg_wdata = v;
    @(posedge clk); #1;
    reg_wr_en = 1'b0;
  endtask

  task automatic do_stop();
    @(negedge clk); stop_req = 1'b1;
    @(posedge clk); #1; stop_req = 1'b0; osc_run = 1'b0;
    chk(stop_active == 1'b1 && clk_en == 1'b0, "R7 stop entry",
        int'({stop_active, clk_en}), 2);
  endtask

  task automatic do_wake();
    @(negedge clk); wake_req = 1'b1;
    @(posedge clk); #1; wake_req = 1'b0;
    chk(stop_active == 1'b0 && clk_en == 1'b0, "R7 wake exit",
        int'({stop_active, clk_en}), 0);
  endtask

  // counts edges until clk_en reads 1; optional oscillator dropout,
  // stop pulse and register write injected at given edge counts
  task automatic measure(int expn, string tag, int drop_at, int drop_len,
                         int stop_at, int wr_at, logic [7:0] wr_val);
    int k = 0;
    bit seen = 1'b0;
    while (!seen && k < 20000) begin
      osc_run   = !(k >= drop_at && k < drop_at + drop_len);
      stop_req  = (k == stop_at);
      reg_wr_en = (k == wr_at);
      reg_wr_byte = 1'b1; reg_wdata = wr_val;
      @(posedge clk); #1;
      k++;
      if (clk_en) seen = 1'b1;
    end
    stop_req = 1'b0; reg_wr_en = 1'b0; osc_run = 1'b1;
    chk(k == expn, tag, k, expn);
    chk(settle_done == 1'b1, "R9 done with enable", int'(settle_done), 1);
    for (int j = 0; j < 3; j++) begin
      @(posedge clk); #1;
      chk(settle_done == 1'b0 && clk_en == 1'b1, "R9 idle after done",
          int'({settle_done, clk_en}), 1);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    rst = 1'b1; stop_req = 1'b0; wake_req = 1'b0; osc_run = 1'b0;
    reg_wr_en = 1'b0; reg_wr_byte = 1'b0; reg_wdata = 8'h00;
    repeat (3) @(posedge clk); #1;
    // R1 reset state
    chk(reg_rdata == 8'h04, "R1 reset readback", int'(reg_rdata), 4);
    chk({clk_en, stop_active, settle_done} == 3'b000, "R1 reset outputs",
        int'({clk_en, stop_active, settle_done}), 0);
    rst = 1'b0;
    #0;
    chk(reg_rdata == 8'h04 && clk_en == 1'b0, "R1 after release",
        int'(reg_rdata), 4);
    // R5 fixed reset wait, with a register write inside it (code 0)
    measure(1 << (19 - S), "R5 reset release wait", 0, 0, -1, 10, 8'h00);
    chk(reg_rdata == 8'h00, "R2 write during reset wait", int'(reg_rdata), 0);

    // vector table: R2 readback and R4 wait length per code
    for (int i = 0; i < 8; i++) begin
      wr(1'b1, VWR[i]);
      chk(reg_rdata == VRD[i], "R2 readback", int'(reg_rdata), int'(VRD[i]));
      do_stop();
      do_wake();
      measure(wait_len(VRD[i][2:0]), "R4 code wait", 0, 0, -1, -1, 8'h00);
    end

    // R3 non-byte write ignored (register holds 7)
    wr(1'b0, 8'h01);
    chk(reg_rdata == 8'h07, "R3 non-byte write", int'(reg_rdata), 7);

    // R6 oscillator low at start, then dropout mid-wait
    wr(1'b1, 8'h01);
    do_stop(); do_wake();
    measure(64 + 3, "R6 start-up not counted", 0, 3, -1, -1, 8'h00);
    do_stop(); do_wake();
    measure(64 + 5, "R6 dropout not counted", 20, 5, -1, -1, 8'h00);

    // R8 write during wait deferred
    do_stop(); do_wake();
    measure(64, "R8 current wait unchanged", 0, 0, -1, 5, 8'h02);
    do_stop(); do_wake();
    measure(128, "R8 new code next release", 0, 0, -1, -1, 8'h00);

    // R10 wake while running ignored
    @(negedge clk); wake_req = 1'b1;
    @(posedge clk); #1; wake_req = 1'b0;
    @(posedge clk); #1;
    chk({clk_en, stop_active, settle_done} == 3'b100, "R10 wake while running",
        int'({clk_en, stop_active, settle_done}), 4);
    // R10 stop during wait ignored
    do_stop(); do_wake();
    measure(128, "R10 stop during wait", 0, 0, 4, -1, 8'h00);

    finish_run();
  end
endmodule